// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the read-side slave front end of a byte-wide serial memory reached over a two-wire (I2C-style) bus. It oversamples the bus clock and data lines with the system clock, detects Start and Stop conditions, and decodes the device select byte against three strapped chip-select inputs. A write-direction select followed by two address bytes (a "dummy write") loads an internal byte address counter. A read-direction select then streams bytes from the internal array, starting at that counter value.

The counter is shared by every read mode and is kept across transfers. A read with no dummy write in front of it therefore continues from where the last one left off. After each byte is output the counter advances by one, and it wraps from the top of the array to zero. The master keeps a sequential read going by acknowledging each byte. Without an acknowledge the slave releases the line and falls back to standby. The slave pulls SDA low through an open-drain enable and never drives it high. The array holds 2**MEM_AW bytes and is filled through a plain preload port.

Top module: `twi_mem_reader`

## Requirements
- R1: A select byte is accepted only when it is 1010 followed by three bits equal to `chip_sel_i` and then the direction bit (1 = read). An accepted select is acknowledged by pulling SDA low during the ninth clock. A mismatched select is not acknowledged, and the slave leaves SDA released until the next Start.
- R2: A random read is a write-direction select, then a high address byte and a low address byte (high byte first), each acknowledged. After a repeated Start and a read-direction select, the slave returns the byte at that address. Address bits at or above MEM_AW are ignored.
- R3: A current address read returns the byte at the counter value. After every byte output, acknowledged or not, the counter advances by one. Its value persists from one transfer to the next.
- R4: When the master acknowledges a read byte (SDA low on the ninth clock), the slave outputs the byte at the next consecutive address on the following eight clocks.
- R5: After the byte at address 2**MEM_AW-1, the counter wraps and the next byte output is the byte at address 0.
- R6: If SDA is high on the ninth clock after a read byte, the slave enters standby and drives nothing on any later clock until a new Start.
- R7: A Start or a Stop at any point aborts the transfer in progress. An address phase cut short this way leaves the counter unchanged.
- R8: After reset the counter is 0 and SDA is released.
- R9: The slave changes its SDA drive only while SCL is low, and shifts each data byte out most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| chip_sel_i | input | 3 | Strapped chip-select value compared with the select byte |
| ld_en_i | input | 1 | Preload write enable for the array |
| ld_addr_i | input | MEM_AW | Preload address |
| ld_data_i | input | 8 | Preload data byte |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
A wrong counter value shows up as a wrong data byte on the very next read byte. This happens whether the next read is a sequential continuation, a fresh current address read or a wrap. The bench therefore keeps its own counter model and compares every returned byte against the preloaded pattern. A control state that fails to drop to standby after a missing acknowledge, a mismatched select or an abort shows up within the next nine SCL clocks as a stray low bit or a stray acknowledge. The bench clocks idle bytes with SDA released after each of those events and expects to read all ones.

// File: rtl/twi_mem_reader.sv
module twi_mem_reader #(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_sel_i,
  input  logic              ld_en_i,
  input  logic [MEM_AW-1:0] ld_addr_i,
  input  logic [7:0]        ld_data_i,
  output logic              sda_oe_o
);

  localparam int DEPTH = 2 ** MEM_AW;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_RD} st_t;

  st_t               st;
  logic [2:0]        scl_p, sda_p;
  logic [3:0]        bitc;
  logic [7:0]        sh, ahi;
  logic [6:0]        tx;
  logic [MEM_AW-1:0] cnt;
  logic [7:0]        mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];
  wire rise  = scl_s & ~scl_q;
  wire fall  = ~scl_s & scl_q;
  wire start = scl_s & scl_q & sda_q & ~sda_s;
  wire stop  = scl_s & scl_q & ~sda_q & sda_s;

  wire [7:0] rd_byte = mem[cnt];
  wire       sel_ok  = sh[7:1] == {4'b1010, chip_sel_i};

  always_ff @(posedge clk) begin
    if (ld_en_i) mem[ld_addr_i] <= ld_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitc     <= 4'd0;
      sh       <= 8'd0;
      ahi      <= 8'd0;
      tx       <= 7'd0;
      cnt      <= '0;
      sda_oe_o <= 1'b0;
    end else if (start) begin
      st       <= S_DEV;
      bitc     <= 4'd0;
      sda_oe_o <= 1'b0;
    end else if (stop) begin
      st       <= S_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_AHI, S_ALO: begin
          if (rise && bitc < 4'd8) begin
            sh   <= {sh[6:0], sda_s};
            bitc <= bitc + 4'd1;
          end else if (fall && bitc == 4'd8) begin
            if (st == S_DEV && !sel_ok) begin
              st <= S_IDLE;
            end else begin
              sda_oe_o <= 1'b1;
              bitc     <= 4'd9;
            end
          end else if (fall && bitc == 4'd9) begin
            bitc     <= 4'd0;
            sda_oe_o <= 1'b0;
            case (st)
              S_DEV: begin
                if (sh[0]) begin
                  st       <= S_RD;
                  tx       <= rd_byte[6:0];
                  sda_oe_o <= ~rd_byte[7];
                  bitc     <= 4'd1;
                end else begin
                  st <= S_AHI;
                end
              end
              S_AHI: begin
                ahi <= sh;
                st  <= S_ALO;
              end
              default: begin
                cnt <= MEM_AW'({ahi, sh});
                st  <= S_IDLE;
              end
            endcase
          end
        end
        S_RD: begin
          if (fall && bitc >= 4'd1 && bitc <= 4'd7) begin
            sda_oe_o <= ~tx[6];
            tx       <= {tx[5:0], 1'b0};
            bitc     <= bitc + 4'd1;
          end else if (fall && bitc == 4'd8) begin
            sda_oe_o <= 1'b0;
            bitc     <= 4'd9;
          end else if (rise && bitc == 4'd9) begin
            cnt <= cnt + 1'b1;
            if (sda_s) st <= S_IDLE;
            else       bitc <= 4'd10;
          end else if (fall && bitc == 4'd10) begin
            tx       <= rd_byte[6:0];
            sda_oe_o <= ~rd_byte[7];
            bitc     <= 4'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire        in_idle  = st == S_IDLE;
  wire        in_dev   = st == S_DEV;
  wire        ack_slot = st == S_RD && bitc == 4'd9;
  wire        in_rd    = st == S_RD;
  wire [15:0] cnt_ext  = 16'(cnt);

endmodule

// File: rtl/twi_mem_reader_chk.sv
module twi_mem_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic        in_idle,
  input logic        in_dev,
  input logic        in_rd,
  input logic        ack_slot,
  input logic        rise,
  input logic        sda_s,
  input logic        start,
  input logic        stop,
  input logic [15:0] cnt_ext
);

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i); // R9

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe_o); // R6

  AST_NACK_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && rise && sda_s) |=> in_idle); // R6

  AST_START_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> in_dev); // R7

  AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> in_idle); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_rd) && cnt_ext != $past(cnt_ext)) |->
      (cnt_ext == $past(cnt_ext) + 16'd1 || cnt_ext == 16'd0)); // R3

endmodule

bind twi_mem_reader twi_mem_reader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .in_idle  (in_idle),
  .in_dev   (in_dev),
  .in_rd    (in_rd),
  .ack_slot (ack_slot),
  .rise     (rise),
  .sda_s    (sda_s),
  .start    (start),
  .stop     (stop),
  .cnt_ext  (cnt_ext)
);

// File: tb/sim_twi_mem_reader.sv
module sim_twi_mem_reader;
  localparam int AW   = 11;
  localparam int MASK = (1 << AW) - 1;
  localparam int HP   = 10;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] SEL_RD = {4'b1010, CS, 1'b1};
  localparam logic [7:0] SEL_WR = {4'b1010, CS, 1'b0};
  localparam logic [7:0] SEL_BAD = {4'b1010, 3'b011, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = 8'd0;
  logic sda_oe;
  wire  sda_bus = ~(m_low | sda_oe);

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twi_mem_reader #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .chip_sel_i(CS), .ld_en_i(ld_en), .ld_addr_i(ld_addr),
    .ld_data_i(ld_data), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29) ^ (a >> 5) ^ 8'h6B);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp(int n = HP);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    hp(2); m_low = 1'b0; hp(); scl = 1'b1; hp(); m_low = 1'b1; hp(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    hp(2); m_low = 1'b1; hp(); scl = 1'b1; hp(); m_low = 1'b0; hp();
  endtask

  task automatic put_bit(bit b);
    hp(2); m_low = ~b; hp(); scl = 1'b1; hp(); scl = 1'b0;
  endtask

  task automatic get_bit(output bit b);
    hp(2); m_low = 1'b0; hp(); scl = 1'b1; hp(HP / 2); b = sda_bus; hp(HP / 2); scl = 1'b0;
  endtask

  task automatic put_byte(logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(bit m_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      get_bit(b);
      v[i] = b;
    end
    put_bit(~m_ack);
  endtask

  task automatic current_read(int n, string tag);
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte(SEL_RD, a);
    chk(a == 1'b0, {tag, " select ack"}, a, 0);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, v);
      chk(v == pat(exp_cnt), tag, v, pat(exp_cnt));
      exp_cnt = (exp_cnt + 1) & MASK;
    end
    bus_stop();
  endtask

  task automatic random_read(logic [15:0] addr, int n, string tag);
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte(SEL_WR, a);  chk(a == 1'b0, "R2 write select ack", a, 0);
    put_byte(addr[15:8], a); chk(a == 1'b0, "R2 high address ack", a, 0);
    put_byte(addr[7:0], a);  chk(a == 1'b0, "R2 low address ack", a, 0);
    exp_cnt = int'(addr) & MASK;
    bus_start();
    put_byte(SEL_RD, a);  chk(a == 1'b0, "R2 read select ack", a, 0);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, v);
      chk(v == pat(exp_cnt), tag, v, pat(exp_cnt));
      exp_cnt = (exp_cnt + 1) & MASK;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R8 SDA released after reset", sda_oe, 0);
    current_read(1, "R8 first read from address 0");
    current_read(1, "R3 counter persists and advances");
  endtask

  task automatic t_mismatch();
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte(SEL_BAD, a);
    chk(a == 1'b1, "R1 mismatched select not acknowledged", a, 1);
    get_byte(1'b0, v);
    chk(v == 8'hFF, "R1 silent after mismatch", v, 8'hFF);
    bus_stop();
    current_read(1, "R1 counter untouched by mismatch");
  endtask

  task automatic t_random();
    random_read(16'hE123, 1, "R2 random read, upper bits ignored");
    random_read(16'h0456, 1, "R2 random read second address");
    current_read(1, "R3 current read after random read");
  endtask

  task automatic t_sequential();
    random_read(16'h0200, 4, "R4 sequential byte");
    current_read(2, "R3 continues after sequential read");
  endtask

  task automatic t_wrap();
    random_read(16'h07FE, 4, "R5 wrap across top address");
    chk(exp_cnt == 2, "R5 model counter after wrap", exp_cnt, 2);
  endtask

  task automatic t_nack();
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte(SEL_RD, a);
    chk(a == 1'b0, "R6 select ack", a, 0);
    get_byte(1'b0, v);
    chk(v == pat(exp_cnt), "R6 byte before nack", v, pat(exp_cnt));
    exp_cnt = (exp_cnt + 1) & MASK;
    get_byte(1'b1, v);
    chk(v == 8'hFF, "R6 no drive after nack", v, 8'hFF);
    get_byte(1'b0, v);
    chk(v == 8'hFF, "R6 still standby", v, 8'hFF);
    bus_stop();
    current_read(1, "R3 counter advanced by nacked byte");
  endtask

  task automatic t_abort();
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte(SEL_WR, a);
    put_byte(8'h03, a);
    bus_stop();
    current_read(1, "R7 stop mid address keeps counter");
    bus_start();
    put_byte(SEL_WR, a);
    put_byte(8'h01, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start();
    put_byte(SEL_RD, a);
    chk(a == 1'b0, "R7 restart mid byte acknowledged", a, 0);
    get_byte(1'b0, v);
    chk(v == pat(exp_cnt), "R7 restart keeps counter", v, pat(exp_cnt));
    exp_cnt = (exp_cnt + 1) & MASK;
    bus_stop();
  endtask

  initial begin
    hp(4);
    rst_n = 1'b1;
    hp(2);
    for (int i = 0; i <= MASK; i++) begin
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = pat(i);
      @(negedge clk);
    end
    ld_en = 1'b0;
    hp();
    t_reset();
    t_mismatch();
    t_random();
    t_sequential();
    t_wrap();
    t_nack();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule